// File: doc/BRIEF.md
# Audio Sample Queue with Attention Threshold

This block is a small first-in first-out buffer for 32-bit audio words, 16 entries deep by default. It sits between a serial audio shifter and the system side of an audio port. A build-time parameter sets its direction. In the playback (transmit) build, software or a transfer engine fills it and the shifter drains it. In the capture (receive) build, the shifter fills it and the system side drains it. Both data paths are valid/ready streams.

The upstream side is held off with `push_ready`, which is low when the queue is full or being cleared. The downstream side is told there is data with `pop_valid`, which is low when the queue is empty or being cleared. A side that ignores these signals is not blocked. A push offered while full is discarded. A pop requested while empty returns a zero word. In the build that owns the matching fault, that event also latches a sticky error flag: a capture build latches it on overrun, and a playback build latches it on underrun.

The block reports a 5-bit level. The capture build reports how many entries hold data. The playback build reports how many entries are free. An attention flag rises when that level reaches a threshold picked by a 2-bit code. The flag is gated by its own interrupt enable.

Top module: `audio_data_fifo`

## Requirements
- R1: After reset the queue is empty, `pop_valid` is 0, `push_ready` is 1 and `err_flag` is 0. The capture build reports level 0 and the playback build reports level 16.
- R2: Words leave on `pop_data` in the order they were accepted, and `pop_data` is valid in the cycle that `pop_ready` is high with `pop_valid` high.
- R3: `level` equals the number of filled entries in the capture build (`IS_TX`=0) and the number of free entries in the playback build (`IS_TX`=1), updated one cycle after each accepted transfer.
- R4: `atn_sel` picks the threshold: 0 selects 1 slot, 1 selects 4, 2 selects 8 and 3 selects 12. `atn_flag` is 1 exactly when `level` is at least that threshold.
- R5: `atn_irq` is `atn_flag` gated by `atn_ie`, so it is 0 whenever `atn_ie` is 0.
- R6: A push while full is dropped and leaves the contents and level unchanged. In the capture build it sets `err_flag` on the next cycle.
- R7: A pop while empty yields a zero `pop_data` and leaves the level unchanged. In the playback build it sets `err_flag` on the next cycle.
- R8: `err_flag` stays set until a cycle with `err_clr` high clears it. If a new fault occurs in that same cycle, the flag stays 1.
- R9: A cycle with `clear` high empties the queue by the next cycle. Push and pop are ignored and raise no fault in that cycle. `err_flag` is not affected.
- R10: A push and a pop accepted in the same cycle leave the level unchanged. A push offered while full, in the same cycle as a pop, is still dropped, because fullness is judged at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous empty request |
| push_valid | input | 1 | Upstream offers a word |
| push_ready | output | 1 | Room available and not clearing |
| push_data | input | 32 | Word offered upstream |
| pop_valid | output | 1 | A word is available |
| pop_ready | input | 1 | Downstream takes a word |
| pop_data | output | 32 | Head word, zero when `pop_valid` is 0 |
| atn_sel | input | 2 | Threshold code |
| atn_ie | input | 1 | Attention interrupt enable |
| level | output | 5 | Filled (capture) or free (playback) count |
| atn_flag | output | 1 | Level at or above threshold |
| atn_irq | output | 1 | Enabled attention |
| err_clr | input | 1 | Write-1 clear of the sticky error |
| err_flag | output | 1 | Sticky overrun or underrun |

## Verification
The properties assume the inputs are free of X after reset and are sampled only at rising edges. They also assume `err_clr` and `clear` are ordinary one-cycle requests, with no ordering relation to the stream handshakes. The stimulus changes every input just after a falling edge and holds it across one rising edge. Both builds receive identical input streams, so the same sequence exercises the overrun path in one build and the underrun path in the other. Handshake violations are issued on purpose, because they are the events being checked.

// File: rtl/adf_pkg.sv
package adf_pkg;

  typedef enum logic [1:0] {
    ATN_ONE    = 2'd0,
    ATN_FOUR   = 2'd1,
    ATN_EIGHT  = 2'd2,
    ATN_TWELVE = 2'd3
  } atn_code_e;

  // Attention threshold in slots for a given code.
  function automatic int unsigned adf_threshold(input logic [1:0] code);
    case (atn_code_e'(code))
      ATN_ONE:   return 1;
      ATN_FOUR:  return 4;
      ATN_EIGHT: return 8;
      default:   return 12;
    endcase
  endfunction

endpackage

// File: rtl/adf_store.sv
module adf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           wr_en,
  input  logic [WIDTH-1:0]               wr_data,
  input  logic                           rd_en,
  output logic [WIDTH-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0]     fill
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/adf_attn.sv
module adf_attn
  import adf_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] lvl,
  input  logic [1:0]       sel,
  input  logic             ie,
  output logic             flag,
  output logic             irq
);
  logic [CNT_W-1:0] thr;

  always_comb begin
    thr  = CNT_W'(adf_threshold(sel));
    flag = (lvl >= thr);
    irq  = flag & ie;
  end
endmodule

// File: rtl/adf_sticky.sv
module adf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_i,
  output logic flag_o
);
  // A fault in the clearing cycle wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (flag_o & ~clr_i) | event_i;
  end
endmodule

// File: rtl/audio_data_fifo.sv
module audio_data_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  parameter bit          IS_TX = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic [WIDTH-1:0]           push_data,
  output logic                       pop_valid,
  input  logic                       pop_ready,
  output logic [WIDTH-1:0]           pop_data,
  input  logic [1:0]                 atn_sel,
  input  logic                       atn_ie,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       atn_flag,
  output logic                       atn_irq,
  input  logic                       err_clr,
  output logic                       err_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fill;
  logic [WIDTH-1:0] head;
  logic             full, empty, wr_ok, rd_ok, fault;

  assign full       = (fill == FULL_CNT);
  assign empty      = (fill == '0);
  assign push_ready = ~full & ~clear;
  assign pop_valid  = ~empty & ~clear;
  assign wr_ok      = push_valid & push_ready;
  assign rd_ok      = pop_ready & pop_valid;
  assign pop_data   = pop_valid ? head : '0;

  adf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .wr_en(wr_ok), .wr_data(push_data),
    .rd_en(rd_ok), .rd_data(head), .fill(fill)
  );

  generate
    if (IS_TX) begin : g_tx
      assign level = FULL_CNT - fill;
      assign fault = pop_ready & empty & ~clear;
    end else begin : g_rx
      assign level = fill;
      assign fault = push_valid & full & ~clear;
    end
  endgenerate

  adf_attn #(.CNT_W(CNT_W)) attn_i (
    .lvl(level), .sel(atn_sel), .ie(atn_ie),
    .flag(atn_flag), .irq(atn_irq)
  );

  adf_sticky err_i (
    .clk(clk), .rst_n(rst_n), .event_i(fault),
    .clr_i(err_clr), .flag_o(err_flag)
  );
endmodule

// File: rtl/audio_data_fifo_chk.sv
module audio_data_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter bit          IS_TX = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clear,
  input logic                       push_valid,
  input logic                       push_ready,
  input logic                       pop_valid,
  input logic                       pop_ready,
  input logic                       atn_ie,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       atn_irq,
  input logic                       err_clr,
  input logic                       err_flag
);
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !atn_ie |-> !atn_irq);

  a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready && !clear && !(pop_valid && pop_ready) |=> $stable(level));

  a_r7_empty_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready && !pop_valid && !clear && !push_valid |=> $stable(level));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pop_valid && push_ready);

  generate
    if (IS_TX) begin : g_tx
      a_r7_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ready && !pop_valid && !clear |=> err_flag);
    end else begin : g_rx
      a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !push_ready && !clear |=> err_flag);
    end
  endgenerate
endmodule

bind audio_data_fifo audio_data_fifo_chk #(.DEPTH(DEPTH), .IS_TX(IS_TX)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .push_valid(push_valid), .push_ready(push_ready),
  .pop_valid(pop_valid), .pop_ready(pop_ready),
  .atn_ie(atn_ie), .level(level), .atn_irq(atn_irq),
  .err_clr(err_clr), .err_flag(err_flag)
);

// File: tb/audio_data_fifo_tb_top.sv
module audio_data_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0, push_valid = 1'b0, pop_ready = 1'b0;
  logic        atn_ie = 1'b0, err_clr = 1'b0;
  logic [1:0]  atn_sel = 2'd0;
  logic [31:0] push_data = '0;

  logic        rx_pr, rx_pv, rx_af, rx_ai, rx_ef;
  logic        tx_pr, tx_pv, tx_af, tx_ai, tx_ef;
  logic [31:0] rx_pd, tx_pd;
  logic [4:0]  rx_lv, tx_lv;

  int n_tests = 0, n_fail = 0;
  int cnt = 0;
  bit err_rx = 0, err_tx = 0;
  logic [31:0] sb[$];

  always #5 clk = ~clk;

  audio_data_fifo #(.IS_TX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push_valid(push_valid), .push_ready(rx_pr), .push_data(push_data),
    .pop_valid(rx_pv), .pop_ready(pop_ready), .pop_data(rx_pd),
    .atn_sel(atn_sel), .atn_ie(atn_ie), .level(rx_lv),
    .atn_flag(rx_af), .atn_irq(rx_ai), .err_clr(err_clr), .err_flag(rx_ef));

  audio_data_fifo #(.IS_TX(1'b1)) dut_tx_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push_valid(push_valid), .push_ready(tx_pr), .push_data(push_data),
    .pop_valid(tx_pv), .pop_ready(pop_ready), .pop_data(tx_pd),
    .atn_sel(atn_sel), .atn_ie(atn_ie), .level(tx_lv),
    .atn_flag(tx_af), .atn_irq(tx_ai), .err_clr(err_clr), .err_flag(tx_ef));

  // R4 mapping: code 0->1, 1->4, 2->8, 3->12 slots
  function automatic int thr_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 12;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic status(input string req);
    bit fr, ft;
    fr = (cnt >= thr_of(atn_sel));
    ft = ((16 - cnt) >= thr_of(atn_sel));
    chk(rx_lv == 5'(cnt), req, "rx level", 32'(rx_lv), 32'(cnt));
    chk(tx_lv == 5'(16 - cnt), req, "tx level", 32'(tx_lv), 32'(16 - cnt));
    chk(rx_pv == (cnt > 0) && tx_pv == (cnt > 0), req, "pop_valid", 32'(rx_pv), 32'(cnt > 0));
    chk(rx_pr == (cnt < 16) && tx_pr == (cnt < 16), req, "push_ready", 32'(rx_pr), 32'(cnt < 16));
    chk(rx_af == fr && tx_af == ft, req, "atn_flag R4", {rx_af, tx_af}, {fr, ft});
    chk(rx_ai == (fr & atn_ie) && tx_ai == (ft & atn_ie), req, "atn_irq R5",
        {rx_ai, tx_ai}, {fr & atn_ie, ft & atn_ie});
    chk(rx_ef == err_rx && tx_ef == err_tx, req, "err_flag", {rx_ef, tx_ef}, {err_rx, err_tx});
  endtask

  // Driver and monitor for one cycle; scoreboard in sb.
  task automatic op(input bit psh, input logic [31:0] d, input bit pop,
                    input bit clr, input bit eclr, input string req);
    logic [31:0] expd;
    bit ovf, udf;
    push_valid = psh; push_data = d; pop_ready = pop; clear = clr; err_clr = eclr;
    #1;
    if (pop && !clr) begin
      expd = (cnt == 0) ? 32'h0 : sb[0];
      chk(rx_pd == expd, req, "rx pop_data", rx_pd, expd);
      chk(tx_pd == expd, req, "tx pop_data", tx_pd, expd);
    end
    ovf = psh && (cnt == 16) && !clr;
    udf = pop && (cnt == 0) && !clr;
    err_rx = (err_rx & ~eclr) | ovf;
    err_tx = (err_tx & ~eclr) | udf;
    if (clr) begin
      cnt = 0; sb.delete();
    end else begin
      bit wok;
      wok = psh && (cnt < 16);
      if (pop && cnt > 0) begin void'(sb.pop_front()); cnt--; end
      if (wok) begin sb.push_back(d); cnt++; end
    end
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop_ready = 0; clear = 0; err_clr = 0;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    status("R1");

    // R2/R3: push five, check level, then sweep attention codes
    for (int i = 0; i < 5; i++) op(1, 32'hA000_0000 + i, 0, 0, 0, "R2");
    status("R3");
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 2; e++) begin
        atn_sel = 2'(s); atn_ie = e[0];
        #1;
        status("R4");
      end
    end
    atn_sel = 2'd2; atn_ie = 1'b1;
    for (int i = 0; i < 5; i++) op(0, 0, 1, 0, 0, "R2");
    status("R3");

    // R7: pop from empty gives zero; playback build latches underrun
    op(0, 0, 1, 0, 0, "R7");
    status("R7");
    op(0, 0, 0, 0, 1, "R8");
    status("R8");

    // R6: fill, then push into full
    atn_sel = 2'd3;
    for (int i = 0; i < 16; i++) op(1, 32'hB000_0000 + i, 0, 0, 0, "R3");
    status("R3");
    op(1, 32'hDEAD_BEEF, 0, 0, 0, "R6");
    status("R6");

    // R10: pop and push together while full: push dropped
    op(0, 0, 0, 0, 1, "R8");
    op(1, 32'hFEED_0001, 1, 0, 0, "R10");
    status("R10");
    for (int i = 0; i < 7; i++) op(0, 0, 1, 0, 0, "R2");
    op(1, 32'hC0DE_0001, 1, 0, 0, "R10");
    status("R10");

    // R8: new fault in the clearing cycle keeps the flag
    while (cnt < 16) op(1, 32'hE000_0000 + cnt, 0, 0, 0, "R6");
    op(1, 32'h1234_5678, 0, 0, 1, "R8");
    status("R8");

    // R9: clear empties but keeps errors; transfers in that cycle ignored
    op(1, 32'h5555_AAAA, 1, 1, 0, "R9");
    status("R9");
    op(1, 32'h0000_0011, 0, 0, 0, "R9");
    op(1, 32'h0000_0022, 0, 0, 0, "R9");
    op(0, 0, 1, 0, 0, "R9");
    op(0, 0, 1, 0, 0, "R9");
    status("R9");
    op(0, 0, 1, 0, 0, "R7");
    status("R7");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule